// File: doc/BRIEF.md
# Stepper Motor Step/Direction Sequencer

This block drives one stepper motor driver through a pulse line and a direction line. A start command supplies the number of steps and the rotation sense. The block then emits that many step pulses. The high time of each pulse and the gap between pulses are programmed in multiples of a 10 µs tick. A prescaler derives that tick from the system clock. An abort command stops a running sequence at once. A busy flag is high while a sequence runs.

Two line encodings are supported, and the encoding is captured at start. In the normal encoding, step pulses always appear on the pulse line and the direction line gives the rotation sense. In the enhanced encoding, clockwise steps appear on the pulse line. Counter-clockwise steps appear on the direction line while the pulse line stays low.

Two limit-switch inputs are watched. Each has a selectable polarity and a common reporting enable. For each switch the block reports its present level. It also keeps a sticky flag that records that the switch became active since the last status read, so a touch is not lost when the motor backs off again.

Top module: `stp_sequencer`

## Requirements
- R1: After reset, `pulse_o`, `dir_o` and `busy_o` are low, and both sticky endstop flags are low.
- R2: In normal mode (`mode_enh_i`=0 at start) each step gives one high pulse on `pulse_o`. While busy, `dir_o` equals the start direction (`start_ccw_i`=1 gives high for counter-clockwise, 0 gives low for clockwise).
- R3: The tick counter restarts on an accepted start, and a tick lasts `CLK_PER_TICK` clocks. Each step is high for `width_i` ticks and, except after the last step, low for `delay_i` ticks. A setting of 0 counts as 1. The first step rises in the clock after the accepting edge.
- R4: In enhanced mode with clockwise direction, steps appear on `pulse_o` and `dir_o` stays low.
- R5: In enhanced mode with counter-clockwise direction, steps appear on `dir_o` and `pulse_o` stays low.
- R6: `busy_o` is high from the accepting edge until the high phase of the last step ends. No gap follows the last step.
- R7: A start command that arrives while busy is ignored. The running sequence continues unchanged.
- R8: A start with a step count of 0 completes at once: `busy_o` stays low and no pulse is emitted.
- R9: An abort ends any sequence at the next clock edge, so that `busy_o`, `pulse_o` and `dir_o` are low in the following cycle. An abort takes priority over a start in the same cycle.
- R10: An endstop level output is high when its input equals the active level (high when `es_act_low_i`=0, low when it is 1), after `SYNC_STAGES` synchroniser clocks. It is forced low while `es_en_i`=0.
- R11: A sticky flag is set when its endstop level output rises, and it stays set without a status read.
- R12: A `stat_rd_i` cycle clears both sticky flags, except that a level rise in that same cycle sets its flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command strobe |
| start_steps_i | input | CNT_W | Step count carried by the start command |
| start_ccw_i | input | 1 | Direction of the start command, 1 = counter-clockwise |
| abort_i | input | 1 | Abort the running sequence |
| mode_enh_i | input | 1 | Line encoding, 1 = enhanced, 0 = normal |
| width_i | input | TIME_W | Pulse high time in ticks |
| delay_i | input | TIME_W | Gap between pulses in ticks |
| es_cw_i | input | 1 | Clockwise limit switch input |
| es_ccw_i | input | 1 | Counter-clockwise limit switch input |
| es_act_low_i | input | 1 | Endstop polarity, 1 = active low |
| es_en_i | input | 1 | Endstop reporting enable |
| stat_rd_i | input | 1 | Status read strobe, clears the sticky flags |
| pulse_o | output | 1 | Step pulse line |
| dir_o | output | 1 | Direction line |
| busy_o | output | 1 | Sequence running |
| es_cw_lvl_o | output | 1 | Present clockwise endstop level |
| es_ccw_lvl_o | output | 1 | Present counter-clockwise endstop level |
| es_cw_seen_o | output | 1 | Clockwise endstop became active since the last read |
| es_ccw_seen_o | output | 1 | Counter-clockwise endstop became active since the last read |

## Verification
Random sequences vary the step count, the direction, the encoding and the two time settings, including zero settings. Every output line is compared against a cycle-exact waveform model, so a wrong tick alignment, a wrong width or gap, a trailing gap after the last step, or a swapped line in either encoding shows up as a mismatch. Directed cases cover a zero step count, an abort in mid-sequence, and a second start while busy; the model keeps running unchanged for that second start. The limit-switch cases cover both polarities, the disabled state, persistence of the sticky flag after release, a clearing read, and a read in the same cycle as a rise.

// File: rtl/stp_pkg.sv
package stp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HIGH = 2'd1,
      ST_LOW  = 2'd2
   } stp_state_e;
endpackage

// File: rtl/stp_tick.sv
module stp_tick #(
   parameter int CLK_PER_TICK = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   localparam int PC_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
   localparam logic [PC_W-1:0] LAST = PC_W'(CLK_PER_TICK - 1);

   logic [PC_W-1:0] pc_q;

   assign tick_o = (pc_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i || tick_o) pc_q <= '0;
      else                           pc_q <= pc_q + 1'b1;
   end
endmodule

// File: rtl/stp_seq.sv
module stp_seq
   import stp_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int TIME_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  steps_i,
   input  logic              ccw_i,
   input  logic              enh_i,
   input  logic              abort_i,
   input  logic [TIME_W-1:0] width_i,
   input  logic [TIME_W-1:0] delay_i,
   output logic              tick_clr_o,
   output logic              step_o,
   output logic              busy_o,
   output logic              ccw_o,
   output logic              enh_o
);
   stp_state_e        st_q;
   logic [CNT_W-1:0]  left_q;
   logic [TIME_W-1:0] tcnt_q, w_q, d_q;
   logic [TIME_W-1:0] w_last, d_last;
   logic              accept;

   assign accept     = (st_q == ST_IDLE) && start_i && !abort_i && (steps_i != '0);
   assign tick_clr_o = accept;
   assign w_last     = (w_q == '0) ? '0 : w_q - 1'b1;
   assign d_last     = (d_q == '0) ? '0 : d_q - 1'b1;
   assign step_o     = (st_q == ST_HIGH);
   assign busy_o     = (st_q != ST_IDLE);
   assign ccw_o      = ccw_q;
   assign enh_o      = enh_q;

   logic ccw_q, enh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         left_q <= '0;
         tcnt_q <= '0;
         w_q    <= '0;
         d_q    <= '0;
         ccw_q  <= 1'b0;
         enh_q  <= 1'b0;
      end else if (abort_i) begin
         st_q   <= ST_IDLE;
         tcnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               st_q   <= ST_HIGH;
               left_q <= steps_i;
               tcnt_q <= '0;
               w_q    <= width_i;
               d_q    <= delay_i;
               ccw_q  <= ccw_i;
               enh_q  <= enh_i;
            end
            ST_HIGH: if (tick_i) begin
               if (tcnt_q == w_last) begin
                  tcnt_q <= '0;
                  left_q <= left_q - 1'b1;
                  st_q   <= (left_q == CNT_W'(1)) ? ST_IDLE : ST_LOW;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            ST_LOW: if (tick_i) begin
               if (tcnt_q == d_last) begin
                  tcnt_q <= '0;
                  st_q   <= ST_HIGH;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/stp_endstop.sv
module stp_endstop #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic act_low_i,
   input  logic en_i,
   input  logic rd_i,
   output logic lvl_o,
   output logic seen_o
);
   logic synced;
   logic prev_q, seen_q, rise;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = raw_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], raw_i};
      end
      if (SYNC_STAGES == 1) begin : g_one
         assign synced = sh_q[0];
      end else begin : g_many
         assign synced = sh_q[SYNC_STAGES-1];
      end
   end

   assign lvl_o  = en_i & (synced ^ act_low_i);
   assign rise   = lvl_o & ~prev_q;
   assign seen_o = seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         prev_q <= lvl_o;
         seen_q <= rise | (seen_q & ~rd_i);
      end
   end
endmodule

// File: rtl/stp_sequencer.sv
module stp_sequencer #(
   parameter int CLK_PER_TICK = 1000,
   parameter int CNT_W        = 16,
   parameter int TIME_W       = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  start_steps_i,
   input  logic              start_ccw_i,
   input  logic              abort_i,
   input  logic              mode_enh_i,
   input  logic [TIME_W-1:0] width_i,
   input  logic [TIME_W-1:0] delay_i,
   input  logic              es_cw_i,
   input  logic              es_ccw_i,
   input  logic              es_act_low_i,
   input  logic              es_en_i,
   input  logic              stat_rd_i,
   output logic              pulse_o,
   output logic              dir_o,
   output logic              busy_o,
   output logic              es_cw_lvl_o,
   output logic              es_ccw_lvl_o,
   output logic              es_cw_seen_o,
   output logic              es_ccw_seen_o
);
   localparam int N_ES = 2;

   if (CLK_PER_TICK < 1) begin : g_bad_tick
      $error("CLK_PER_TICK must be at least 1");
   end
   if (CNT_W < 1 || TIME_W < 1) begin : g_bad_width
      $error("CNT_W and TIME_W must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic tick, tick_clr, step, ccw, enh;

   stp_tick #(.CLK_PER_TICK(CLK_PER_TICK)) tick_i (
      .clk(clk), .rst_n(rst_n), .clr_i(tick_clr), .tick_o(tick)
   );

   stp_seq #(.CNT_W(CNT_W), .TIME_W(TIME_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .start_i(start_i), .steps_i(start_steps_i), .ccw_i(start_ccw_i),
      .enh_i(mode_enh_i), .abort_i(abort_i),
      .width_i(width_i), .delay_i(delay_i),
      .tick_clr_o(tick_clr), .step_o(step), .busy_o(busy_o),
      .ccw_o(ccw), .enh_o(enh)
   );

   always_comb begin
      if (!busy_o) begin
         pulse_o = 1'b0;
         dir_o   = 1'b0;
      end else if (enh) begin
         pulse_o = step & ~ccw;
         dir_o   = step & ccw;
      end else begin
         pulse_o = step;
         dir_o   = ccw;
      end
   end

   logic [N_ES-1:0] es_raw, es_lvl, es_seen;
   assign es_raw = {es_ccw_i, es_cw_i};

   for (genvar g = 0; g < N_ES; g++) begin : g_es
      stp_endstop #(.SYNC_STAGES(SYNC_STAGES)) es_i (
         .clk(clk), .rst_n(rst_n), .raw_i(es_raw[g]),
         .act_low_i(es_act_low_i), .en_i(es_en_i), .rd_i(stat_rd_i),
         .lvl_o(es_lvl[g]), .seen_o(es_seen[g])
      );
   end

   assign es_cw_lvl_o   = es_lvl[0];
   assign es_ccw_lvl_o  = es_lvl[1];
   assign es_cw_seen_o  = es_seen[0];
   assign es_ccw_seen_o = es_seen[1];
endmodule

// File: rtl/stp_sequencer_chk.sv
module stp_sequencer_chk (
   input logic clk,
   input logic rst_n,
   input logic abort_i,
   input logic start_i,
   input logic zero_steps,
   input logic es_en_i,
   input logic stat_rd_i,
   input logic pulse_o,
   input logic dir_o,
   input logic busy_o,
   input logic es_cw_seen_o,
   input logic es_ccw_seen_o
);
   // R9: abort leaves everything idle one cycle later
   a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!busy_o && !pulse_o && !dir_o));

   // R8: a zero step count never starts a sequence
   a_r8_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && zero_steps && !busy_o) |=> !busy_o);

   // R6: a pulse is only emitted while busy
   a_r6_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o || dir_o) |-> busy_o);

   // R11: sticky flag holds without a read
   a_r11_seen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (es_cw_seen_o && !stat_rd_i) |=> es_cw_seen_o);

   // R10: a flag can only be set while reporting was enabled
   a_r10_seen_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(es_ccw_seen_o) |-> $past(es_en_i));
endmodule

bind stp_sequencer stp_sequencer_chk chk_i (
   .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .start_i(start_i),
   .zero_steps(start_steps_i == '0), .es_en_i(es_en_i), .stat_rd_i(stat_rd_i),
   .pulse_o(pulse_o), .dir_o(dir_o), .busy_o(busy_o),
   .es_cw_seen_o(es_cw_seen_o), .es_ccw_seen_o(es_ccw_seen_o)
);

// File: tb/stp_sequencer_tb.sv
module stp_sequencer_tb_top;
   localparam int P = 5;
   localparam int CW = 16;
   localparam int TW = 8;

   logic clk = 0, rst_n = 0;
   logic start = 0, ccw = 0, abort = 0, enh = 0;
   logic [CW-1:0] steps = '0;
   logic [TW-1:0] width = '0, delay = '0;
   logic es_cw = 0, es_ccw = 0, act_low = 0, es_en = 1, rd = 0;
   logic pulse, dir, busy, lcw, lccw, scw, sccw;
   int vec = 0, miss = 0;

   always #5 clk = ~clk;

   stp_sequencer #(.CLK_PER_TICK(P), .CNT_W(CW), .TIME_W(TW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_steps_i(steps),
      .start_ccw_i(ccw), .abort_i(abort), .mode_enh_i(enh),
      .width_i(width), .delay_i(delay), .es_cw_i(es_cw), .es_ccw_i(es_ccw),
      .es_act_low_i(act_low), .es_en_i(es_en), .stat_rd_i(rd),
      .pulse_o(pulse), .dir_o(dir), .busy_o(busy),
      .es_cw_lvl_o(lcw), .es_ccw_lvl_o(lccw),
      .es_cw_seen_o(scw), .es_ccw_seen_o(sccw)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   // expected {busy, pulse, dir} t clocks after the accepting edge (R2-R6, R3 timing)
   function automatic logic [2:0] model(int t, int n, int w, int d, bit c, bit e);
      int per, ph, idx, tot;
      bit st, b;
      per = (eff(w) + eff(d)) * P;
      tot = n * eff(w) * P + (n - 1) * eff(d) * P;
      b   = (t < tot);
      idx = t / per;
      ph  = t % per;
      st  = b && (idx < n) && (ph < eff(w) * P);
      if (!b)     return 3'b000;
      if (e)      return {1'b1, st & ~c, st & c};
      return {1'b1, st, c};
   endfunction

   task automatic run_seq(int n, bit c, bit e, int w, int d, int abort_at, int inj_at);
      int tot;
      bit aborted = 0;
      logic [2:0] ex;
      string tg;
      tot = n * eff(w) * P + (n - 1) * eff(d) * P;
      steps = CW'(n); ccw = c; enh = e; width = TW'(w); delay = TW'(d);
      start = 1;
      @(negedge clk);
      start = 0;
      for (int t = 0; t < tot + 3; t++) begin
         ex = aborted ? 3'b000 : model(t, n, w, d, c, e);
         tg = aborted ? "R9" : (inj_at >= 0 && t > inj_at) ? "R7" :
              (e && c) ? "R5" : e ? "R4" : "R2";
         check(tg, {29'd0, pulse, dir}, {29'd0, ex[1:0]});
         check(aborted ? "R9" : "R6", {31'd0, busy}, {31'd0, ex[2]});
         abort = 0; start = 0;
         if (t == abort_at) begin abort = 1; aborted = 1; end
         if (t == inj_at) begin
            start = 1; steps = CW'(n + 3); ccw = ~c; width = TW'(w + 2);
         end
         @(negedge clk);
      end
      abort = 0; start = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1", {28'd0, pulse, dir, busy, scw | sccw}, 32'd0);

      // R8 zero steps
      steps = '0; start = 1; width = 1; delay = 1;
      @(negedge clk); start = 0;
      check("R8", {30'd0, busy, pulse}, 32'd0);
      @(negedge clk);
      check("R8", {30'd0, busy, pulse}, 32'd0);

      // directed sequences, incl. zero time settings (R3)
      run_seq(3, 0, 0, 1, 1, -1, -1);
      run_seq(2, 1, 0, 0, 0, -1, -1);
      run_seq(2, 1, 1, 2, 1, -1, -1);
      run_seq(3, 0, 1, 1, 2, -1, -1);
      // R7 start while busy is ignored
      run_seq(3, 0, 0, 2, 1, -1, 4);
      // R9 abort mid-sequence, then a fresh start works
      run_seq(4, 1, 0, 2, 2, 13, -1);
      run_seq(1, 1, 1, 1, 0, -1, -1);

      // constrained random runs
      for (int i = 0; i < 12; i++) begin
         run_seq(int'($urandom_range(1, 5)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), -1, -1);
      end

      // endstops: disabled input is ignored (R10)
      es_en = 0; es_cw = 1;
      repeat (4) @(negedge clk);
      check("R10", {31'd0, lcw}, 32'd0);
      check("R10", {31'd0, scw}, 32'd0);
      es_en = 1;
      repeat (4) @(negedge clk);
      check("R10", {31'd0, lcw}, 32'd1);
      check("R11", {31'd0, scw}, 32'd1);
      es_cw = 0;
      repeat (4) @(negedge clk);
      check("R10", {31'd0, lcw}, 32'd0);
      check("R11", {31'd0, scw}, 32'd1);
      rd = 1; @(negedge clk); rd = 0;
      check("R12", {31'd0, scw}, 32'd0);
      // R12 rise in the same cycle as the read wins
      es_ccw = 1;
      @(negedge clk);
      @(negedge clk);
      rd = 1;
      @(negedge clk);
      rd = 0;
      check("R12", {31'd0, sccw}, 32'd1);
      rd = 1; @(negedge clk); rd = 0;
      check("R12", {31'd0, sccw}, 32'd0);
      // R10 active-low polarity
      act_low = 1; es_cw = 0; es_ccw = 1;
      repeat (4) @(negedge clk);
      check("R10", {31'd0, lcw}, 32'd1);
      check("R10", {31'd0, lccw}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end
endmodule